// File: doc/BRIEF.md
# Data-Flash Sector Erase Launch Guard

This block sits between a command register file and a data-flash erase engine. It looks at a sector-erase request in the cycle it is launched. It decides whether the request may run, and it reports the outcome through sticky flags and two interrupt lines.

A request is refused if any of the following is wrong: the count of loaded command words, the current operating mode, the target address range, or the word alignment. Any of these raises the access-error flag. A well-formed request whose sector lies inside the configured protected range is refused with a protection-violation flag instead.

An accepted request starts a behavioural erase. A counter stands in for the erase time, and verify-result strobes are sampled while it runs. The completion flag drops while work is in progress and returns high when the block is ready again. Read-path ECC fault strobes feed two further sticky flags, which drive the error interrupt.

Top module: `dflash_erase_guard`

## Requirements
- R1: After reset, `cmd_done` is 1 and every flag and both interrupt lines are 0.
- R2: A launch whose `cmd_idx` differs from 3'b001 sets `acc_err`, does not start an erase, and holds `cmd_done` low for exactly one cycle.
- R3: A launch in an operating mode whose bit in `MODE_OK_MASK` is 0 sets `acc_err`. By default, modes 0 and 1 are allowed and modes 2 and 3 are refused.
- R4: A launch whose address is below `WIN_LO` (default 18'h04000) or above `WIN_HI` (default 18'h04FFF) sets `acc_err`.
- R5: A launch whose address has bit 0 equal to 1 sets `acc_err`.
- R6: A launch with no access fault sets `prot_err` and leaves `acc_err` at 0 when all of these hold: `prot_en` is 1, and the sector number (address bits [17:8]) is between `prot_lo` and `prot_hi`, inclusive. The erase is not started, and `cmd_done` is low for one cycle.
- R7: A launch with no fault drops `cmd_done` for exactly `ERASE_CYC` cycles (default 20), after which it returns to 1.
- R8: While an erase runs, a high `vfy_err` sets `vfy_any_flag`, and a high `vfy_fatal` sets both `vfy_any_flag` and `vfy_fatal_flag`. The same strobes have no effect while no erase is running.
- R9: `irq_cmd` is high exactly when `cmd_done` and `cc_ie` are both high.
- R10: `irq_err` is high exactly when (`dbl_flag` and `dbl_ie`) or (`sgl_flag` and `sgl_ie`).
- R11: All six flags are sticky and clear only by writing 1 to their bit of `flag_clr`. The bit map is: [0] access error, [1] protection violation, [2] any verify error, [3] fatal verify error, [4] double-bit fault, [5] single-bit fault. When a set and a clear of the same flag arrive together, the set wins.
- R12: A launch is ignored while `acc_err` or `prot_err` is set, and while an erase runs.
- R13: A high `ecc_dbl` sets `dbl_flag`, and a high `ecc_sgl` sets `sgl_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | One-cycle command launch strobe |
| cmd_idx | input | 3 | Index of the last loaded command word |
| op_mode | input | 2 | Current operating mode |
| tgt_addr | input | 18 | Global target address |
| prot_en | input | 1 | Enables the protected sector range |
| prot_lo | input | 10 | First protected sector |
| prot_hi | input | 10 | Last protected sector |
| vfy_err | input | 1 | Verify found an error (sampled during erase) |
| vfy_fatal | input | 1 | Verify found a non-correctable error |
| ecc_dbl | input | 1 | Double-bit ECC fault strobe on read |
| ecc_sgl | input | 1 | Single-bit ECC fault strobe on read |
| flag_clr | input | 6 | Write-1-to-clear for the six flags |
| cc_ie | input | 1 | Completion interrupt enable |
| dbl_ie | input | 1 | Double-bit fault interrupt enable |
| sgl_ie | input | 1 | Single-bit fault interrupt enable |
| cmd_done | output | 1 | Command complete / ready |
| acc_err | output | 1 | Access-error flag |
| prot_err | output | 1 | Protection-violation flag |
| vfy_any_flag | output | 1 | Verify found any error |
| vfy_fatal_flag | output | 1 | Verify found a non-correctable error |
| dbl_flag | output | 1 | Double-bit fault flag |
| sgl_flag | output | 1 | Single-bit fault flag |
| irq_cmd | output | 1 | Completion interrupt request |
| irq_err | output | 1 | ECC error interrupt request |

## Verification
A sequencer stuck in the refusal or erase state shows within one cycle of the expected return as `cmd_done` staying low, and it also blocks later launches. An off-by-one in the erase counter shifts the rising edge of `cmd_done` by one cycle, so the cycle-by-cycle comparison catches it. A flag set in the wrong category, or a flag that clears by itself, differs from the reference model in the cycle after the launch or the clear. The interrupt lines follow the flags and enables without delay, so a wrong gate shows the first time the enables are toggled against a set flag.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_REFUSE = 2'd1,
      SEQ_ERASE  = 2'd2
   } seq_state_e;

   localparam int FLAG_N      = 6;
   localparam int FL_ACC      = 0;
   localparam int FL_PROT     = 1;
   localparam int FL_VFY_ANY  = 2;
   localparam int FL_VFY_FAT  = 3;
   localparam int FL_DBL      = 4;
   localparam int FL_SGL      = 5;

   typedef struct packed {
      logic fmt_bad;
      logic mode_bad;
      logic range_bad;
      logic align_bad;
      logic prot_hit;
   } launch_verdict_t;

   function automatic logic any_access_fault(launch_verdict_t v);
      return v.fmt_bad | v.mode_bad | v.range_bad | v.align_bad;
   endfunction

endpackage

// File: rtl/dfe_launch_check.sv
module dfe_launch_check
   import dfe_pkg::*;
#(
   parameter int                      ADDR_W       = 18,
   parameter int                      IDX_W        = 3,
   parameter int                      IDX_EXPECT   = 1,
   parameter int                      MODE_W       = 2,
   parameter logic [(1<<MODE_W)-1:0]  MODE_OK_MASK = 4'b0011,
   parameter logic [ADDR_W-1:0]       WIN_LO       = 18'h04000,
   parameter logic [ADDR_W-1:0]       WIN_HI       = 18'h04FFF,
   parameter int                      SECT_SHIFT   = 8,
   localparam int                     SECT_W       = ADDR_W - SECT_SHIFT,
   localparam int                     MODE_N       = 1 << MODE_W
) (
   input  logic [IDX_W-1:0]   cmd_idx,
   input  logic [MODE_W-1:0]  op_mode,
   input  logic [ADDR_W-1:0]  tgt_addr,
   input  logic               prot_en,
   input  logic [SECT_W-1:0]  prot_lo,
   input  logic [SECT_W-1:0]  prot_hi,
   output launch_verdict_t    verdict
);

   logic [MODE_N-1:0] mode_hit;
   logic [SECT_W-1:0] sector;

   for (genvar m = 0; m < MODE_N; m++) begin : g_mode
      assign mode_hit[m] = (op_mode == MODE_W'(m)) & MODE_OK_MASK[m];
   end

   assign sector = tgt_addr[ADDR_W-1:SECT_SHIFT];

   always_comb begin
      verdict           = '0;
      verdict.fmt_bad   = (cmd_idx != IDX_W'(IDX_EXPECT));
      verdict.mode_bad  = ~(|mode_hit);
      verdict.range_bad = (tgt_addr < WIN_LO) | (tgt_addr > WIN_HI);
      verdict.align_bad = tgt_addr[0];
      verdict.prot_hit  = prot_en & (sector >= prot_lo) & (sector <= prot_hi);
   end

endmodule

// File: rtl/dfe_erase_seq.sv
module dfe_erase_seq
   import dfe_pkg::*;
#(
   parameter int  ERASE_CYC = 20,
   localparam int CNT_W     = (ERASE_CYC > 1) ? $clog2(ERASE_CYC) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic refuse,
   input  logic vfy_err,
   input  logic vfy_fatal,
   output logic ready,
   output logic vfy_any_set,
   output logic vfy_fat_set
);

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy;

   assign busy        = (state_q == SEQ_ERASE);
   assign ready       = (state_q == SEQ_IDLE);
   assign vfy_any_set = busy & (vfy_err | vfy_fatal);
   assign vfy_fat_set = busy & vfy_fatal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (refuse) begin
                  state_q <= SEQ_REFUSE;
               end else if (go) begin
                  state_q <= SEQ_ERASE;
                  cnt_q   <= CNT_W'(ERASE_CYC - 1);
               end
            end
            SEQ_REFUSE: state_q <= SEQ_IDLE;
            SEQ_ERASE: begin
               if (cnt_q == '0) state_q <= SEQ_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q <= CNT_W'(ERASE_CYC - 1)));

   p_refuse_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_REFUSE) |=> ready);

   p_no_start_on_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && refuse) |=> !busy);

endmodule

// File: rtl/dfe_sticky_flags.sv
module dfe_sticky_flags #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[i]) q <= 1'b1;
         else if (clr_i[i]) q <= 1'b0;
      end
      assign flags_o[i] = q;

      p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !flags_o[i]);

      p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flags_o[i]);

      p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
   end

endmodule

// File: rtl/dfe_irq_gen.sv
module dfe_irq_gen (
   input  logic cmd_done,
   input  logic cc_ie,
   input  logic dbl_flag,
   input  logic dbl_ie,
   input  logic sgl_flag,
   input  logic sgl_ie,
   output logic irq_cmd,
   output logic irq_err
);

   assign irq_cmd = cmd_done & cc_ie;
   assign irq_err = (dbl_flag & dbl_ie) | (sgl_flag & sgl_ie);

endmodule

// File: rtl/dflash_erase_guard.sv
module dflash_erase_guard
   import dfe_pkg::*;
#(
   parameter int                      ADDR_W       = 18,
   parameter int                      IDX_W        = 3,
   parameter int                      IDX_EXPECT   = 1,
   parameter int                      MODE_W       = 2,
   parameter logic [(1<<MODE_W)-1:0]  MODE_OK_MASK = 4'b0011,
   parameter logic [ADDR_W-1:0]       WIN_LO       = 18'h04000,
   parameter logic [ADDR_W-1:0]       WIN_HI       = 18'h04FFF,
   parameter int                      SECT_SHIFT   = 8,
   parameter int                      ERASE_CYC    = 20,
   localparam int                     SECT_W       = ADDR_W - SECT_SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic [IDX_W-1:0]   cmd_idx,
   input  logic [MODE_W-1:0]  op_mode,
   input  logic [ADDR_W-1:0]  tgt_addr,
   input  logic               prot_en,
   input  logic [SECT_W-1:0]  prot_lo,
   input  logic [SECT_W-1:0]  prot_hi,
   input  logic               vfy_err,
   input  logic               vfy_fatal,
   input  logic               ecc_dbl,
   input  logic               ecc_sgl,
   input  logic [5:0]         flag_clr,
   input  logic               cc_ie,
   input  logic               dbl_ie,
   input  logic               sgl_ie,
   output logic               cmd_done,
   output logic               acc_err,
   output logic               prot_err,
   output logic               vfy_any_flag,
   output logic               vfy_fatal_flag,
   output logic               dbl_flag,
   output logic               sgl_flag,
   output logic               irq_cmd,
   output logic               irq_err
);

   initial begin
      assert (WIN_LO <= WIN_HI) else $error("window bounds reversed");
      assert (ERASE_CYC >= 1) else $error("erase length must be positive");
      assert (SECT_SHIFT > 0 && SECT_SHIFT < ADDR_W) else $error("bad sector shift");
      assert (IDX_EXPECT < (1 << IDX_W)) else $error("index does not fit");
   end

   launch_verdict_t    verdict;
   logic               acc_fault;
   logic               prot_fault;
   logic               accept;
   logic               ready;
   logic               vfy_any_set;
   logic               vfy_fat_set;
   logic [FLAG_N-1:0]  flag_set;
   logic [FLAG_N-1:0]  flags;

   dfe_launch_check #(
      .ADDR_W       (ADDR_W),
      .IDX_W        (IDX_W),
      .IDX_EXPECT   (IDX_EXPECT),
      .MODE_W       (MODE_W),
      .MODE_OK_MASK (MODE_OK_MASK),
      .WIN_LO       (WIN_LO),
      .WIN_HI       (WIN_HI),
      .SECT_SHIFT   (SECT_SHIFT)
   ) u_check (
      .cmd_idx  (cmd_idx),
      .op_mode  (op_mode),
      .tgt_addr (tgt_addr),
      .prot_en  (prot_en),
      .prot_lo  (prot_lo),
      .prot_hi  (prot_hi),
      .verdict  (verdict)
   );

   assign acc_fault  = any_access_fault(verdict);
   assign prot_fault = ~acc_fault & verdict.prot_hit;
   assign accept     = launch & ready & ~flags[FL_ACC] & ~flags[FL_PROT];

   dfe_erase_seq #(
      .ERASE_CYC (ERASE_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (accept & ~acc_fault & ~prot_fault),
      .refuse      (accept & (acc_fault | prot_fault)),
      .vfy_err     (vfy_err),
      .vfy_fatal   (vfy_fatal),
      .ready       (ready),
      .vfy_any_set (vfy_any_set),
      .vfy_fat_set (vfy_fat_set)
   );

   always_comb begin
      flag_set             = '0;
      flag_set[FL_ACC]     = accept & acc_fault;
      flag_set[FL_PROT]    = accept & prot_fault;
      flag_set[FL_VFY_ANY] = vfy_any_set;
      flag_set[FL_VFY_FAT] = vfy_fat_set;
      flag_set[FL_DBL]     = ecc_dbl;
      flag_set[FL_SGL]     = ecc_sgl;
   end

   dfe_sticky_flags #(
      .N (FLAG_N)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (flag_set),
      .clr_i   (flag_clr),
      .flags_o (flags)
   );

   assign cmd_done       = ready;
   assign acc_err        = flags[FL_ACC];
   assign prot_err       = flags[FL_PROT];
   assign vfy_any_flag   = flags[FL_VFY_ANY];
   assign vfy_fatal_flag = flags[FL_VFY_FAT];
   assign dbl_flag       = flags[FL_DBL];
   assign sgl_flag       = flags[FL_SGL];

   dfe_irq_gen u_irq (
      .cmd_done (cmd_done),
      .cc_ie    (cc_ie),
      .dbl_flag (dbl_flag),
      .dbl_ie   (dbl_ie),
      .sgl_flag (sgl_flag),
      .sgl_ie   (sgl_ie),
      .irq_cmd  (irq_cmd),
      .irq_err  (irq_err)
   );

   p_acc_on_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && acc_fault) |=> (acc_err && !cmd_done));

   p_prot_not_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !acc_fault && verdict.prot_hit) |=> (prot_err && !acc_err));

   p_fall_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_done) |-> $past(accept));

   p_fatal_implies_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vfy_fatal_flag) |-> vfy_any_flag);

   p_blocked_launch_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && (acc_err || prot_err)) |=> cmd_done);

endmodule

// File: tb/dflash_erase_guard_bench.sv
module dflash_erase_guard_bench;

   localparam int ECYC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        launch = 1'b0;
   logic [2:0]  cmd_idx = 3'd1;
   logic [1:0]  op_mode = 2'd0;
   logic [17:0] tgt_addr = 18'h04000;
   logic        prot_en = 1'b0;
   logic [9:0]  prot_lo = 10'd0;
   logic [9:0]  prot_hi = 10'd0;
   logic        vfy_err = 1'b0;
   logic        vfy_fatal = 1'b0;
   logic        ecc_dbl = 1'b0;
   logic        ecc_sgl = 1'b0;
   logic [5:0]  flag_clr = 6'd0;
   logic        cc_ie = 1'b0;
   logic        dbl_ie = 1'b0;
   logic        sgl_ie = 1'b0;
   logic cmd_done, acc_err, prot_err, vfy_any_flag, vfy_fatal_flag;
   logic dbl_flag, sgl_flag, irq_cmd, irq_err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dflash_erase_guard u_dflash_erase_guard (
      .clk(clk), .rst_n(rst_n), .launch(launch), .cmd_idx(cmd_idx),
      .op_mode(op_mode), .tgt_addr(tgt_addr), .prot_en(prot_en),
      .prot_lo(prot_lo), .prot_hi(prot_hi), .vfy_err(vfy_err),
      .vfy_fatal(vfy_fatal), .ecc_dbl(ecc_dbl), .ecc_sgl(ecc_sgl),
      .flag_clr(flag_clr), .cc_ie(cc_ie), .dbl_ie(dbl_ie), .sgl_ie(sgl_ie),
      .cmd_done(cmd_done), .acc_err(acc_err), .prot_err(prot_err),
      .vfy_any_flag(vfy_any_flag), .vfy_fatal_flag(vfy_fatal_flag),
      .dbl_flag(dbl_flag), .sgl_flag(sgl_flag), .irq_cmd(irq_cmd),
      .irq_err(irq_err)
   );

   // Behavioural reference: 0 idle, 1 refused, 2 erasing
   int m_st = 0;
   int m_left = 0;
   bit [5:0] m_fl = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_left = 0; m_fl = '0;
      end else begin
         bit [5:0] s;
         bit bad;
         bit hit;
         int sec;
         s = '0;
         sec = int'(tgt_addr) / 256;
         bad = (cmd_idx != 3'd1) || (op_mode > 2'd1) ||
               (tgt_addr < 18'h04000) || (tgt_addr > 18'h04FFF) || tgt_addr[0];
         hit = prot_en && sec >= int'(prot_lo) && sec <= int'(prot_hi);
         if (m_st == 0) begin
            if (launch && !m_fl[0] && !m_fl[1]) begin
               if (bad)      begin s[0] = 1; m_st = 1; end
               else if (hit) begin s[1] = 1; m_st = 1; end
               else          begin m_st = 2; m_left = ECYC; end
            end
         end else if (m_st == 1) begin
            m_st = 0;
         end else begin
            if (vfy_err || vfy_fatal) s[2] = 1;
            if (vfy_fatal) s[3] = 1;
            m_left--;
            if (m_left == 0) m_st = 0;
         end
         s[4] = ecc_dbl;
         s[5] = ecc_sgl;
         m_fl = (m_fl & ~flag_clr) | s;
      end
   end

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R7 cmd_done model",        cmd_done,       m_st == 0);
         chk("R2 acc_err model",         acc_err,        m_fl[0]);
         chk("R6 prot_err model",        prot_err,       m_fl[1]);
         chk("R8 vfy_any model",         vfy_any_flag,   m_fl[2]);
         chk("R8 vfy_fatal model",       vfy_fatal_flag, m_fl[3]);
         chk("R13 dbl_flag model",       dbl_flag,       m_fl[4]);
         chk("R13 sgl_flag model",       sgl_flag,       m_fl[5]);
         chk("R9 irq_cmd model",         irq_cmd,        (m_st == 0) && cc_ie);
         chk("R10 irq_err model",        irq_err,        (m_fl[4] && dbl_ie) || (m_fl[5] && sgl_ie));
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
      end
   end

   task automatic go(logic [2:0] idx, logic [1:0] md, logic [17:0] a);
      @(posedge clk); #1;
      launch = 1; cmd_idx = idx; op_mode = md; tgt_addr = a;
      @(posedge clk); #1;
      launch = 0;
   endtask

   task automatic clear(logic [5:0] m);
      @(posedge clk); #1; flag_clr = m;
      @(posedge clk); #1; flag_clr = '0;
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 200 && !cmd_done; i++) @(negedge clk);
   endtask

   task automatic refused(string tag, logic [2:0] idx, logic [1:0] md, logic [17:0] a);
      go(idx, md, a);
      @(negedge clk);
      chk({tag, " acc_err set"}, acc_err, 1'b1);
      chk({tag, " cmd_done low"}, cmd_done, 1'b0);
      @(negedge clk);
      chk({tag, " cmd_done back"}, cmd_done, 1'b1);
      clear(6'b000001);
      @(negedge clk);
      chk("R11 acc_err cleared", acc_err, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk("R1 cmd_done", cmd_done, 1'b1);
      chk("R1 flags", |{acc_err, prot_err, vfy_any_flag, vfy_fatal_flag, dbl_flag, sgl_flag}, 1'b0);
      chk("R1 irqs", irq_cmd | irq_err, 1'b0);

      // R7: valid erase length
      go(3'd1, 2'd0, 18'h04100);
      begin
         int low = 0;
         for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (cmd_done) break;
            low++;
         end
         chk("R7 erase length", low == ECYC, 1'b1);
      end

      refused("R2", 3'd3, 2'd0, 18'h04100);
      refused("R3", 3'd1, 2'd2, 18'h04100);
      refused("R3", 3'd1, 2'd3, 18'h04100);
      refused("R4", 3'd1, 2'd0, 18'h03FFE);
      refused("R4", 3'd1, 2'd0, 18'h05000);
      refused("R5", 3'd1, 2'd0, 18'h04101);

      // R12: blocked while acc_err set
      go(3'd0, 2'd1, 18'h04000);
      go(3'd1, 2'd1, 18'h04000);
      @(negedge clk);
      chk("R12 ignored while acc_err", cmd_done, 1'b1);
      clear(6'b000001);

      // R6 protection, boundaries
      prot_en = 1; prot_lo = 10'h044; prot_hi = 10'h046;
      go(3'd1, 2'd0, 18'h04600);
      @(negedge clk);
      chk("R6 prot_err", prot_err, 1'b1);
      chk("R6 no acc_err", acc_err, 1'b0);
      @(negedge clk);
      chk("R6 cmd_done back", cmd_done, 1'b1);
      go(3'd1, 2'd0, 18'h04300);
      @(negedge clk);
      chk("R12 ignored while prot_err", cmd_done, 1'b1);
      clear(6'b000010);
      @(negedge clk);
      chk("R11 prot_err cleared", prot_err, 1'b0);
      go(3'd1, 2'd0, 18'h04300);
      @(negedge clk);
      chk("R6 unprotected sector erases", cmd_done, 1'b0);
      go(3'd1, 2'd0, 18'h04600);
      @(negedge clk);
      chk("R12 ignored while busy", prot_err, 1'b0);
      wait_ready();
      prot_en = 0;

      // R8 verify strobes
      vfy_err = 1; @(posedge clk); #1 vfy_err = 0;
      @(negedge clk);
      chk("R8 idle strobe ignored", vfy_any_flag, 1'b0);
      go(3'd1, 2'd1, 18'h04200);
      vfy_err = 1; @(posedge clk); #1 vfy_err = 0;
      @(negedge clk);
      chk("R8 any set", vfy_any_flag, 1'b1);
      chk("R8 fatal clear", vfy_fatal_flag, 1'b0);
      wait_ready();
      clear(6'b000100);
      go(3'd1, 2'd0, 18'h04ffe);
      repeat (5) @(posedge clk);
      #1 vfy_fatal = 1; @(posedge clk); #1 vfy_fatal = 0;
      @(negedge clk);
      chk("R8 fatal sets fatal", vfy_fatal_flag, 1'b1);
      chk("R8 fatal sets any", vfy_any_flag, 1'b1);
      wait_ready();
      clear(6'b001100);

      // R9, R10, R13, R11 set-wins
      cc_ie = 1;
      @(negedge clk);
      chk("R9 irq_cmd", irq_cmd, 1'b1);
      @(posedge clk); #1 ecc_dbl = 1; @(posedge clk); #1 ecc_dbl = 0;
      @(negedge clk);
      chk("R13 dbl_flag", dbl_flag, 1'b1);
      chk("R10 masked", irq_err, 1'b0);
      dbl_ie = 1;
      @(negedge clk);
      chk("R10 dbl path", irq_err, 1'b1);
      @(posedge clk); #1 ecc_sgl = 1; flag_clr = 6'b110000;
      @(posedge clk); #1 ecc_sgl = 0; flag_clr = '0;
      @(negedge clk);
      chk("R11 set wins", sgl_flag, 1'b1);
      chk("R11 dbl cleared", dbl_flag, 1'b0);
      chk("R10 sgl masked", irq_err, 1'b0);
      sgl_ie = 1;
      @(negedge clk);
      chk("R10 sgl path", irq_err, 1'b1);
      cc_ie = 0;
      @(negedge clk);
      chk("R9 irq_cmd masked", irq_cmd, 1'b0);

      repeat (4) @(negedge clk);
      summary();
   end

endmodule